// File: doc/BRIEF.md
# Accumulator Processor with Staged Memory Path

This block is a small multicycle processor with a single accumulator that software can see. It reads 16-bit instruction words from a single-port synchronous memory that returns data one cycle after a read. Every address leaves the core through a memory address register, and every word entering or leaving passes through a memory buffer register. A fetched word is copied from the buffer register into an instruction register before it is decoded.

The instruction set has four operations: load, store, add from memory and add with an immediate value. Each step of the state machine occupies one clock. The program counter, instruction register and accumulator are brought out on debug ports, so a host or bench can follow execution one instruction at a time.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the core loads the program counter with 0x100 and clears the accumulator, instruction register, address register and buffer register. Both strobes are low during reset.
- R2: An instruction word carries its opcode in bits 15:12 and a 12-bit operand in bits 11:0. The operand is either a memory address or an immediate.
- R3: A fetch copies the PC into the address register and then issues one read at that address. The returned word goes into the buffer register and then into the IR. The PC increases by exactly one at that point, before the instruction executes, and changes at no other time.
- R4: Opcode 0 (load) reads memory at the operand address through the address and buffer registers, and places the word in the accumulator.
- R5: Opcode 1 (store) raises the write strobe for one cycle with the address equal to the operand and the write data equal to the accumulator. The accumulator is left unchanged.
- R6: Opcode 2 (add) reads memory at the operand address and adds the word to the accumulator. The sum wraps modulo 2^16.
- R7: Opcode 3 (add immediate) adds the zero-extended 12-bit operand to the accumulator, wrapping modulo 2^16. It makes no data memory access.
- R8: Opcodes 4 to 15 change neither the accumulator nor memory and make no data access. The PC still advances by one.
- R9: The read and write strobes are never high together. Each strobe is high for exactly one cycle per access.
- R10: An instruction takes 8 cycles for load and add, 6 cycles for store, and 5 cycles for add immediate and undefined opcodes. Every instruction makes exactly one fetch read. The store write comes 4 cycles after its fetch read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; the data is returned on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| mem_rdata | input | 16 | Read data from memory |
| dbg_pc | output | 12 | Current program counter |
| dbg_ir | output | 16 | Current instruction register |
| dbg_ac | output | 16 | Current accumulator |

## Verification
The bench first runs the four-instruction example, which ends with 10 in the accumulator and 8 stored at 0x201. It then runs two directed words: an immediate of 0xFFF, which shows whether zero-extension is used instead of sign-extension, and an add of 0xFFFF, which shows whether the sum wraps at 16 bits. After that it sweeps all sixteen opcodes four times with varied operands, against a data region seeded with distinct values. Loads, stores and adds therefore produce different accumulator and memory traces, and undefined opcodes show up at once if they disturb any state. For each instruction, the bench checks the PC, IR and accumulator at the exact cycle count expected for that instruction, along with the number of reads and writes and the address and data of each write. A wrong latency, a missing data access or an extra data access each fails a separate check.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OP_LOAD  = 0;
    localparam int OP_STORE = 1;
    localparam int OP_ADD   = 2;
    localparam int OP_ADDI  = 3;

    typedef enum logic [3:0] {
        ST_F_ADDR,
        ST_F_READ,
        ST_F_LATCH,
        ST_F_IR,
        ST_DECODE,
        ST_X_READ,
        ST_X_LATCH,
        ST_X_ALU,
        ST_X_WRITE
    } state_e;

    // register-transfer enables issued by the sequencer each cycle
    typedef struct packed {
        logic mar_pc;   // address register <- program counter
        logic mar_opd;  // address register <- instruction operand
        logic mbr_mem;  // buffer register <- memory read data
        logic mbr_ac;   // buffer register <- accumulator
        logic ir_mbr;   // instruction register <- buffer register
        logic pc_inc;   // program counter + 1
        logic ac_mem;   // accumulator <- buffer register
        logic ac_sum;   // accumulator <- adder result
        logic sum_imm;  // adder second operand is the immediate
        logic rd;       // memory read strobe
        logic wr;       // memory write strobe
    } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum
);

    // carry out is dropped: the accumulator wraps
    always_comb begin
        sum = a + b;
    end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
#(
    parameter int OPC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctrl
);

    localparam logic [OPC_W-1:0] OPC_LOAD  = OPC_W'(OP_LOAD);
    localparam logic [OPC_W-1:0] OPC_STORE = OPC_W'(OP_STORE);
    localparam logic [OPC_W-1:0] OPC_ADD   = OPC_W'(OP_ADD);
    localparam logic [OPC_W-1:0] OPC_ADDI  = OPC_W'(OP_ADDI);

    state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        ctrl    = '0;
        case (state_q)
            ST_F_ADDR: begin
                ctrl.mar_pc = 1'b1;
                state_d     = ST_F_READ;
            end
            ST_F_READ: begin
                ctrl.rd = 1'b1;
                state_d = ST_F_LATCH;
            end
            ST_F_LATCH: begin
                ctrl.mbr_mem = 1'b1;
                state_d      = ST_F_IR;
            end
            ST_F_IR: begin
                ctrl.ir_mbr = 1'b1;
                ctrl.pc_inc = 1'b1;
                state_d     = ST_DECODE;
            end
            ST_DECODE: begin
                if (opcode == OPC_LOAD || opcode == OPC_ADD) begin
                    ctrl.mar_opd = 1'b1;
                    state_d      = ST_X_READ;
                end else if (opcode == OPC_STORE) begin
                    ctrl.mar_opd = 1'b1;
                    ctrl.mbr_ac  = 1'b1;
                    state_d      = ST_X_WRITE;
                end else if (opcode == OPC_ADDI) begin
                    ctrl.ac_sum  = 1'b1;
                    ctrl.sum_imm = 1'b1;
                    state_d      = ST_F_ADDR;
                end else begin
                    state_d = ST_F_ADDR;
                end
            end
            ST_X_READ: begin
                ctrl.rd = 1'b1;
                state_d = ST_X_LATCH;
            end
            ST_X_LATCH: begin
                ctrl.mbr_mem = 1'b1;
                state_d      = ST_X_ALU;
            end
            ST_X_ALU: begin
                if (opcode == OPC_LOAD) begin
                    ctrl.ac_mem = 1'b1;
                end else begin
                    ctrl.ac_sum = 1'b1;
                end
                state_d = ST_F_ADDR;
            end
            ST_X_WRITE: begin
                ctrl.wr = 1'b1;
                state_d = ST_F_ADDR;
            end
            default: begin
                state_d = ST_F_ADDR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_F_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs
    import acc_cpu_pkg::*;
#(
    parameter int              DATA_W   = 16,
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] RESET_PC = 12'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mbr,
    output logic [DATA_W-1:0] ir,
    output logic [DATA_W-1:0] ac
);

    localparam int IMM_PAD = DATA_W - ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] ac;
    } regs_t;

    regs_t             r_d, r_q;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] add_b;
    logic [DATA_W-1:0] add_sum;

    always_comb begin
        imm_ext = {{IMM_PAD{1'b0}}, r_q.ir[ADDR_W-1:0]};
        add_b   = ctrl.sum_imm ? imm_ext : r_q.mbr;
    end

    acc_cpu_alu #(
        .DATA_W(DATA_W)
    ) alu_i (
        .a  (r_q.ac),
        .b  (add_b),
        .sum(add_sum)
    );

    always_comb begin
        r_d = r_q;
        if (ctrl.mar_pc) begin
            r_d.mar = r_q.pc;
        end
        if (ctrl.mar_opd) begin
            r_d.mar = r_q.ir[ADDR_W-1:0];
        end
        if (ctrl.mbr_mem) begin
            r_d.mbr = mem_rdata;
        end
        if (ctrl.mbr_ac) begin
            r_d.mbr = r_q.ac;
        end
        if (ctrl.ir_mbr) begin
            r_d.ir = r_q.mbr;
        end
        if (ctrl.pc_inc) begin
            r_d.pc = r_q.pc + ADDR_W'(1);
        end
        if (ctrl.ac_mem) begin
            r_d.ac = r_q.mbr;
        end
        if (ctrl.ac_sum) begin
            r_d.ac = add_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.pc <= RESET_PC;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        pc  = r_q.pc;
        mar = r_q.mar;
        mbr = r_q.mbr;
        ir  = r_q.ir;
        ac  = r_q.ac;
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int                DATA_W   = 16,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] RESET_PC = 12'h100
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [DATA_W-1:0] dbg_ir,
    output logic [DATA_W-1:0] dbg_ac
);

    localparam int OPC_W = DATA_W - ADDR_W;

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] pc_w;
    logic [ADDR_W-1:0] mar_w;
    logic [DATA_W-1:0] mbr_w;
    logic [DATA_W-1:0] ir_w;
    logic [DATA_W-1:0] ac_w;
    logic [OPC_W-1:0]  opcode;

    always_comb begin
        opcode = ir_w[DATA_W-1 -: OPC_W];
    end

    acc_cpu_seq #(
        .OPC_W(OPC_W)
    ) seq_i (
        .clk   (clk),
        .rst   (rst),
        .opcode(opcode),
        .ctrl  (ctrl)
    );

    acc_cpu_regs #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .RESET_PC(RESET_PC)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .mem_rdata(mem_rdata),
        .pc       (pc_w),
        .mar      (mar_w),
        .mbr      (mbr_w),
        .ir       (ir_w),
        .ac       (ac_w)
    );

    always_comb begin
        mem_addr  = mar_w;
        mem_wdata = mbr_w;
        mem_rd    = ctrl.rd;
        mem_wr    = ctrl.wr;
        dbg_pc    = pc_w;
        dbg_ir    = ir_w;
        dbg_ac    = ac_w;
    end

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [ADDR_W-1:0] dbg_pc,
    input logic [DATA_W-1:0] dbg_ir,
    input logic [DATA_W-1:0] dbg_ac
);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

    // R9
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R9
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !mem_wr);

    // R5
    store_data_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wdata == dbg_ac));

    // R10
    store_lat_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd, 4));

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dbg_pc) |-> (dbg_pc == $past(dbg_pc) + ADDR_W'(1)));

    // R3
    ir_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dbg_ir) |-> $past(mem_rd, 3));

endmodule

bind acc_cpu acc_cpu_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_wdata(mem_wdata),
    .dbg_pc   (dbg_pc),
    .dbg_ir   (dbg_ir),
    .dbg_ac   (dbg_ac)
);

// File: tb/acc_cpu_tb_top.sv
`timescale 1ns/1ps
module acc_cpu_tb_top;

    localparam int SWEEP_N = 64;
    localparam int WD_CYC  = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [11:0] dbg_pc;
    logic [15:0] dbg_ir;
    logic [15:0] dbg_ac;

    always #4 clk = ~clk;

    acc_cpu dut_i (
        .clk      (clk),
        .rst      (rst),
        .mem_addr (mem_addr),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .dbg_pc   (dbg_pc),
        .dbg_ir   (dbg_ir),
        .dbg_ac   (dbg_ac)
    );

    // memory model with one-cycle read latency and a preload port
    logic [15:0] mem [4096];
    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // strobe monitor
    int          rd_total = 0;
    int          wr_total = 0;
    logic [11:0] last_wa = '0;
    logic [15:0] last_wd = '0;
    always @(posedge clk) begin
        if (!rst) begin
            if (mem_rd) rd_total <= rd_total + 1;
            if (mem_wr) begin
                wr_total <= wr_total + 1;
                last_wa  <= mem_addr;
                last_wd  <= mem_wdata;
            end
        end
    end

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic preload(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = a;
        ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // bench reference state
    logic [15:0] prog [128];
    int          prog_n = 0;
    logic [15:0] ref_dat [16];
    logic [15:0] ref_ac = '0;
    logic [11:0] ref_pc = 12'h100;

    function automatic logic [15:0] init_dat(input int k);
        if (k == 0) return 16'd5;
        if (k == 1) return 16'd3;
        if (k == 2) return 16'd0;
        if (k == 15) return 16'hFFFF;
        return 16'((k * 16'h2345 + 1) & 16'hFFFF);
    endfunction

    task automatic add_instr(input logic [15:0] w);
        prog[prog_n] = w;
        prog_n++;
    endtask

    // run one instruction and compare against the arithmetic model
    task automatic step(input logic [15:0] w);
        int          op;
        int          ncyc;
        int          exp_rd;
        int          exp_wr;
        int          rd0;
        int          wr0;
        logic [11:0] opd;
        string       tag;
        op     = int'(w[15:12]);
        opd    = w[11:0];
        exp_wr = 0;
        exp_rd = 1;
        case (op)
            0: begin ncyc = 8; exp_rd = 2; ref_ac = ref_dat[opd[3:0]]; tag = "R4"; end
            1: begin ncyc = 6; exp_wr = 1; ref_dat[opd[3:0]] = ref_ac; tag = "R5"; end
            2: begin ncyc = 8; exp_rd = 2; ref_ac = ref_ac + ref_dat[opd[3:0]]; tag = "R6"; end
            3: begin ncyc = 5; ref_ac = ref_ac + {4'h0, opd}; tag = "R7"; end
            default: begin ncyc = 5; tag = "R8"; end
        endcase
        ref_pc = ref_pc + 12'd1;
        rd0 = rd_total;
        wr0 = wr_total;
        repeat (ncyc) @(posedge clk);
        @(negedge clk);
        check(tag, "accumulator", 32'(dbg_ac), 32'(ref_ac));
        check("R3", "pc after instruction", 32'(dbg_pc), 32'(ref_pc));
        // R2: IR holds the whole fetched word
        check("R2", "instruction register", 32'(dbg_ir), 32'(w));
        check("R10", "reads per instruction", 32'(rd_total - rd0), 32'(exp_rd));
        check("R10", "writes per instruction", 32'(wr_total - wr0), 32'(exp_wr));
        if (op == 1) begin
            check("R5", "store address", 32'(last_wa), 32'(opd));
            check("R5", "store data", 32'(last_wd), 32'(ref_ac));
            check("R5", "memory word", 32'(mem[opd]), 32'(ref_ac));
        end
    endtask

    initial begin
        // stated example, then directed wrap and extension words
        add_instr(16'h0200);
        add_instr(16'h2201);
        add_instr(16'h1201);
        add_instr(16'h3002);
        add_instr(16'h3FFF);
        add_instr(16'h220F);
        for (int i = 0; i < SWEEP_N; i++) begin
            int op;
            logic [11:0] opd;
            op = i % 16;
            if (op <= 2) opd = 12'(12'h200 + ((i * 5 + 3) % 16));
            else         opd = 12'((i * 613 + 16'h0A5) & 16'hFFF);
            add_instr({4'(op), opd});
        end
        for (int k = 0; k < 16; k++) ref_dat[k] = init_dat(k);

        for (int i = 0; i < prog_n; i++) preload(12'(12'h100 + i), prog[i]);
        for (int k = 0; k < 16; k++) preload(12'(12'h200 + k), ref_dat[k]);

        @(negedge clk);
        check("R1", "reset pc", 32'(dbg_pc), 32'h100);
        check("R1", "reset accumulator", 32'(dbg_ac), 32'h0);
        check("R1", "reset ir", 32'(dbg_ir), 32'h0);
        check("R1", "reset strobes", 32'({mem_rd, mem_wr}), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < prog_n; i++) begin
            step(prog[i]);
            if (i == 3) begin
                check("R5", "example result at 0x201", 32'(mem[12'h201]), 32'd8);
                check("R7", "example accumulator", 32'(dbg_ac), 32'd10);
            end
            if (i == 4) check("R7", "zero-extended 0xFFF", 32'(dbg_ac), 32'h1009);
            if (i == 5) check("R6", "wrapped sum", 32'(dbg_ac), 32'h1008);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule